// File: doc/BRIEF.md
# Sound Co-processor I/O Window Decoder

This block sits between the sound co-processor's memory bus and everything mapped onto it. It watches a 16-bit address with a request strobe and a write flag. Sixteen addresses at 0x00F0..0x00FF form an I/O window. That window holds:

- an indirect register path into the DSP (an address latch plus a data location);
- four byte mailboxes to and from the host, and two scratch bytes;
- the control byte for the timer unit and the boot image;
- the timer targets, and counter readback that clears on read.

A 64-byte boot image can be switched over the top of the address space. Every write also goes through to RAM at the same address, whatever it hits.

Reads have a fixed latency of one cycle. The request cycle registers a read-source state (`rd_src_e`). The cycle after it presents that source's byte. The read-source states are:

- `SRC_ZERO`: write-only locations.
- `SRC_LATCH`: the DSP address latch.
- `SRC_DSP`: DSP register data.
- `SRC_HOST`: bytes from the host.
- `SRC_SCRATCH`: scratch bytes.
- `SRC_TIMER`: timer counters.
- `SRC_ROM`: boot image.
- `SRC_RAM`: memory.

Each read request moves the state to the source that its address decodes to. Reset puts it in `SRC_ZERO`. With no read request, the state holds.

Top module: `spc_io_decoder`

## Requirements
- R1: After reset, the following are all zero: the timer enables, the timer targets, the host output bytes, the scratch bytes, the DSP address latch and the host input bytes. The boot overlay is enabled.
- R2: Reads of 0x00F0, 0x00F1, 0x00FA, 0x00FB and 0x00FC return 0x00.
- R3: 0x00F2 stores the DSP address latch and reads it back as written. A read of 0x00F3 returns the DSP register at the latch's low 7 bits, and `dsp_addr` always equals those 7 bits.
- R4: A write to 0x00F3 pulses `dsp_we` only when the latch is below 0x80. Otherwise the DSP register is left unchanged.
- R5: Writes to 0x00F4..0x00F7 set host output bytes 0..3, where byte k is `host_out[8k+7:8k]`. Reads of those addresses return host input bytes 0..3, which the host loads through `host_wr`/`host_idx`.
- R6: 0x00F8 and 0x00F9 are scratch bytes 0 and 1, which read back as written and appear on `scratch_out`.
- R7: In the control byte at 0x00F1, bits 2:0 drive `tmr_en`. Writes to 0x00FA..0x00FC set target t (t=0..2) on `tmr_target[8t+7:8t]`.
- R8: Control bit 4 clears host input bytes 0 and 1, and bit 5 clears bytes 2 and 3. When a clear and a host write to the same byte fall in the same cycle, the clear wins.
- R9: Control bit 7 enables the boot overlay. While it is set, reads of 0xFFC0..0xFFFF return image byte k = k XOR 0xA5 (default image), where k is the address minus 0xFFC0. 0xFFBF and every address while the overlay is off read RAM.
- R10: Every write, I/O locations and overlay addresses included, drives `ram_we` with the same address and data.
- R11: Reads of 0x00FD..0x00FF return counter t (t=0..2) from `tmr_count[4t+3:4t]`, zero-extended. `tmr_clr[t]` is pulsed only in that request cycle.
- R12: Read data appears on `cpu_rdata` in the cycle after the request. Addresses outside the window and outside an active overlay return `ram_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req | input | 1 | Bus access request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | Bus address |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, one cycle after request |
| ram_addr | output | 16 | RAM address |
| ram_re | output | 1 | RAM read enable |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data (registered, one cycle) |
| dsp_addr | output | 7 | DSP register index |
| dsp_we | output | 1 | DSP register write strobe |
| dsp_wdata | output | 8 | DSP register write data |
| dsp_rdata | input | 8 | DSP register read data |
| host_wr | input | 1 | Host write to an input byte |
| host_idx | input | 2 | Host input byte index |
| host_wdata | input | 8 | Host write data |
| host_out | output | 32 | Output bytes toward host |
| scratch_out | output | 16 | Scratch bytes |
| tmr_en | output | 3 | Timer enables |
| tmr_target | output | 24 | Timer targets |
| tmr_count | input | 12 | Timer counters |
| tmr_clr | output | 3 | Counter clear pulses |

## Verification
The assertions check the following on every cycle:

- the DSP write guard;
- that the latch and control writes land one cycle later;
- that a paired clear empties both bytes;
- that at most one timer clear pulses, and only on a read;
- that RAM sees every write.

Only the bench scenarios can show the rest:

- the full read map, including zero reads and the overlay boundary at 0xFFBF/0xFFC0;
- the one-cycle read latency;
- that a discarded DSP write leaves the register intact;
- a host write colliding with a clear in the same cycle;
- that counter values are routed to the right timer.

// File: rtl/spc_io_pkg.sv
package spc_io_pkg;

    typedef enum logic [2:0] {
        SRC_ZERO,
        SRC_LATCH,
        SRC_DSP,
        SRC_HOST,
        SRC_SCRATCH,
        SRC_TIMER,
        SRC_ROM,
        SRC_RAM
    } rd_src_e;

    localparam int DEF_ROM_BYTES = 64;
    localparam int DEF_DATA_W    = 8;

    // Offsets inside the 16-byte window; software layout depends on them.
    localparam logic [3:0] OFS_CTRL  = 4'd1;
    localparam logic [3:0] OFS_DADDR = 4'd2;
    localparam logic [3:0] OFS_DDATA = 4'd3;
    localparam logic [3:0] OFS_HOST0 = 4'd4;
    localparam logic [3:0] OFS_SCR0  = 4'd8;
    localparam logic [3:0] OFS_TGT0  = 4'd10;
    localparam logic [3:0] OFS_CNT0  = 4'd13;

    // Control byte bit positions.
    localparam int CTL_CLR_LO = 4;
    localparam int CTL_ROM    = 7;

    function automatic logic [DEF_ROM_BYTES*DEF_DATA_W-1:0] default_boot_image();
        logic [DEF_ROM_BYTES*DEF_DATA_W-1:0] img;
        for (int k = 0; k < DEF_ROM_BYTES; k++) begin
            img[k*DEF_DATA_W +: DEF_DATA_W] = DEF_DATA_W'(k) ^ 8'hA5;
        end
        return img;
    endfunction

endpackage

// File: rtl/io_addr_decode.sv
module io_addr_decode
    import spc_io_pkg::*;
#(
    parameter int               ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] IO_BASE  = 16'h00F0,
    parameter int               ROM_BYTES = 64,
    localparam int              ROM_AW    = $clog2(ROM_BYTES)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rom_en,
    output logic              in_io,
    output logic [3:0]        ofs,
    output logic [ROM_AW-1:0] rom_idx,
    output rd_src_e           src
);

    logic    in_rom;
    rd_src_e io_src;

    assign in_io   = (addr[ADDR_W-1:4] == IO_BASE[ADDR_W-1:4]);
    assign in_rom  = rom_en && (&addr[ADDR_W-1:ROM_AW]);
    assign ofs     = addr[3:0];
    assign rom_idx = addr[ROM_AW-1:0];

    always_comb begin
        unique case (ofs)
            4'd2:                   io_src = SRC_LATCH;
            4'd3:                   io_src = SRC_DSP;
            4'd4, 4'd5, 4'd6, 4'd7: io_src = SRC_HOST;
            4'd8, 4'd9:             io_src = SRC_SCRATCH;
            4'd13, 4'd14, 4'd15:    io_src = SRC_TIMER;
            default:                io_src = SRC_ZERO;
        endcase
    end

    always_comb begin
        if (in_io)       src = io_src;
        else if (in_rom) src = SRC_ROM;
        else             src = SRC_RAM;
    end

endmodule

// File: rtl/io_ctrl_regs.sv
module io_ctrl_regs
    import spc_io_pkg::*;
#(
    parameter int  DATA_W   = 8,
    parameter int  NUM_HOST = 4,
    parameter int  NUM_SCR  = 2,
    parameter int  NUM_TMR  = 3,
    parameter int  DSP_AW   = 7,
    localparam int HIDX_W   = $clog2(NUM_HOST)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_io,
    input  logic [3:0]                   ofs,
    input  logic [DATA_W-1:0]            wdata,
    input  logic                         host_wr,
    input  logic [HIDX_W-1:0]            host_idx,
    input  logic [DATA_W-1:0]            host_wdata,
    output logic [DATA_W-1:0]            latch_q,
    output logic                         rom_en,
    output logic [NUM_TMR-1:0]           tmr_en,
    output logic [NUM_TMR*DATA_W-1:0]    tmr_target,
    output logic [NUM_HOST*DATA_W-1:0]   host_in,
    output logic [NUM_HOST*DATA_W-1:0]   host_out,
    output logic [NUM_SCR*DATA_W-1:0]    scratch,
    output logic                         dsp_we,
    output logic [DSP_AW-1:0]            dsp_addr,
    output logic [DATA_W-1:0]            dsp_wdata
);

    logic wr_ctrl;
    assign wr_ctrl = wr_io && (ofs == OFS_CTRL);

    // Latch and control byte.
    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '0;
            rom_en  <= 1'b1;
            tmr_en  <= '0;
        end else begin
            if (wr_io && ofs == OFS_DADDR) latch_q <= wdata;
            if (wr_ctrl) begin
                tmr_en <= wdata[NUM_TMR-1:0];
                rom_en <= wdata[CTL_ROM];
            end
        end
    end

    // Host input bytes: paired clear from the control byte beats a host write.
    always_ff @(posedge clk) begin
        if (rst) begin
            host_in <= '0;
        end else begin
            for (int i = 0; i < NUM_HOST; i++) begin
                if (wr_ctrl && wdata[CTL_CLR_LO + i/2])
                    host_in[i*DATA_W +: DATA_W] <= '0;
                else if (host_wr && host_idx == HIDX_W'(i))
                    host_in[i*DATA_W +: DATA_W] <= host_wdata;
            end
        end
    end

    // Plain byte registers written from the bus.
    always_ff @(posedge clk) begin
        if (rst) begin
            host_out   <= '0;
            scratch    <= '0;
            tmr_target <= '0;
        end else if (wr_io) begin
            for (int i = 0; i < NUM_HOST; i++)
                if (ofs == 4'(OFS_HOST0 + i)) host_out[i*DATA_W +: DATA_W] <= wdata;
            for (int i = 0; i < NUM_SCR; i++)
                if (ofs == 4'(OFS_SCR0 + i)) scratch[i*DATA_W +: DATA_W] <= wdata;
            for (int i = 0; i < NUM_TMR; i++)
                if (ofs == 4'(OFS_TGT0 + i)) tmr_target[i*DATA_W +: DATA_W] <= wdata;
        end
    end

    assign dsp_addr  = latch_q[DSP_AW-1:0];
    assign dsp_wdata = wdata;
    assign dsp_we    = wr_io && (ofs == OFS_DDATA) && !latch_q[DATA_W-1];

    // R4
    dsp_guard_chk: assert property (@(posedge clk) disable iff (rst)
        dsp_we |-> (latch_q < DATA_W'(1 << DSP_AW)) && (dsp_addr == latch_q[DSP_AW-1:0]));

    // R3
    latch_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_io && ofs == OFS_DADDR) |=> latch_q == $past(wdata));

    // R7
    ctrl_wr_chk: assert property (@(posedge clk) disable iff (rst)
        wr_ctrl |=> (tmr_en == $past(wdata[NUM_TMR-1:0])) && (rom_en == $past(wdata[CTL_ROM])));

    // R8
    pair_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && wdata[CTL_CLR_LO]) |=> host_in[2*DATA_W-1:0] == '0);

endmodule

// File: rtl/io_read_path.sv
module io_read_path
    import spc_io_pkg::*;
#(
    parameter int  DATA_W    = 8,
    parameter int  NUM_HOST  = 4,
    parameter int  NUM_SCR   = 2,
    parameter int  NUM_TMR   = 3,
    parameter int  TCNT_W    = 4,
    parameter int  ROM_BYTES = 64,
    parameter logic [ROM_BYTES*DATA_W-1:0] BOOT_IMAGE = default_boot_image(),
    localparam int ROM_AW    = $clog2(ROM_BYTES),
    localparam int HIDX_W    = $clog2(NUM_HOST),
    localparam int SIDX_W    = (NUM_SCR > 1) ? $clog2(NUM_SCR) : 1,
    localparam int TIDX_W    = $clog2(NUM_TMR)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        rd_req,
    input  logic                        in_io,
    input  logic [3:0]                  ofs,
    input  rd_src_e                     src_d,
    input  logic [ROM_AW-1:0]           rom_idx,
    input  logic [DATA_W-1:0]           latch_q,
    input  logic [DATA_W-1:0]           dsp_rdata,
    input  logic [NUM_HOST*DATA_W-1:0]  host_in,
    input  logic [NUM_SCR*DATA_W-1:0]   scratch,
    input  logic [NUM_TMR*TCNT_W-1:0]   tmr_count,
    input  logic [DATA_W-1:0]           ram_rdata,
    output logic [DATA_W-1:0]           cpu_rdata,
    output logic [NUM_TMR-1:0]          tmr_clr
);

    rd_src_e           src_q;
    logic [DATA_W-1:0] io_d, io_q;
    logic [TIDX_W-1:0] tsel;

    assign tsel = TIDX_W'(ofs - OFS_CNT0);

    // Byte for the source selected in this request cycle.
    always_comb begin
        unique case (src_d)
            SRC_ZERO:    io_d = '0;
            SRC_LATCH:   io_d = latch_q;
            SRC_DSP:     io_d = dsp_rdata;
            SRC_HOST:    io_d = host_in[ofs[HIDX_W-1:0]*DATA_W +: DATA_W];
            SRC_SCRATCH: io_d = scratch[ofs[SIDX_W-1:0]*DATA_W +: DATA_W];
            SRC_TIMER:   io_d = DATA_W'(tmr_count[tsel*TCNT_W +: TCNT_W]);
            SRC_ROM:     io_d = BOOT_IMAGE[rom_idx*DATA_W +: DATA_W];
            SRC_RAM:     io_d = '0;
            default:     io_d = '0;
        endcase
    end

    // State register: read source held for the response cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            src_q <= SRC_ZERO;
            io_q  <= '0;
        end else if (rd_req) begin
            src_q <= src_d;
            io_q  <= io_d;
        end
    end

    // Outputs.
    always_comb begin
        unique case (src_q)
            SRC_RAM: cpu_rdata = ram_rdata;
            default: cpu_rdata = io_q;
        endcase
    end

    for (genvar t = 0; t < NUM_TMR; t++) begin : g_clr
        assign tmr_clr[t] = rd_req && in_io && (ofs == 4'(OFS_CNT0 + t));
    end

    // R11
    clr_single_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(tmr_clr));

    // R11
    clr_on_read_chk: assert property (@(posedge clk) disable iff (rst)
        (tmr_clr != '0) |=> src_q == SRC_TIMER);

endmodule

// File: rtl/spc_io_decoder.sv
module spc_io_decoder
    import spc_io_pkg::*;
#(
    parameter int  ADDR_W    = 16,
    parameter int  DATA_W    = 8,
    parameter int  NUM_HOST  = 4,
    parameter int  NUM_SCR   = 2,
    parameter int  NUM_TMR   = 3,
    parameter int  TCNT_W    = 4,
    parameter int  DSP_AW    = 7,
    parameter int  ROM_BYTES = 64,
    parameter logic [ADDR_W-1:0] IO_BASE = 16'h00F0,
    parameter logic [ROM_BYTES*DATA_W-1:0] BOOT_IMAGE = default_boot_image(),
    localparam int ROM_AW    = $clog2(ROM_BYTES),
    localparam int HIDX_W    = $clog2(NUM_HOST)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cpu_req,
    input  logic                        cpu_we,
    input  logic [ADDR_W-1:0]           cpu_addr,
    input  logic [DATA_W-1:0]           cpu_wdata,
    output logic [DATA_W-1:0]           cpu_rdata,
    output logic [ADDR_W-1:0]           ram_addr,
    output logic                        ram_re,
    output logic                        ram_we,
    output logic [DATA_W-1:0]           ram_wdata,
    input  logic [DATA_W-1:0]           ram_rdata,
    output logic [DSP_AW-1:0]           dsp_addr,
    output logic                        dsp_we,
    output logic [DATA_W-1:0]           dsp_wdata,
    input  logic [DATA_W-1:0]           dsp_rdata,
    input  logic                        host_wr,
    input  logic [HIDX_W-1:0]           host_idx,
    input  logic [DATA_W-1:0]           host_wdata,
    output logic [NUM_HOST*DATA_W-1:0]  host_out,
    output logic [NUM_SCR*DATA_W-1:0]   scratch_out,
    output logic [NUM_TMR-1:0]          tmr_en,
    output logic [NUM_TMR*DATA_W-1:0]   tmr_target,
    input  logic [NUM_TMR*TCNT_W-1:0]   tmr_count,
    output logic [NUM_TMR-1:0]          tmr_clr
);

    logic                        in_io, rom_en, wr_io, rd_req;
    logic [3:0]                  ofs;
    logic [ROM_AW-1:0]           rom_idx;
    rd_src_e                     src_d;
    logic [DATA_W-1:0]           latch_q;
    logic [NUM_HOST*DATA_W-1:0]  host_in;

    assign wr_io  = cpu_req && cpu_we && in_io;
    assign rd_req = cpu_req && !cpu_we;

    // Every write falls through to RAM.
    assign ram_addr  = cpu_addr;
    assign ram_we    = cpu_req && cpu_we;
    assign ram_re    = rd_req;
    assign ram_wdata = cpu_wdata;

    io_addr_decode #(
        .ADDR_W(ADDR_W), .IO_BASE(IO_BASE), .ROM_BYTES(ROM_BYTES)
    ) u_dec (
        .addr(cpu_addr), .rom_en(rom_en), .in_io(in_io), .ofs(ofs),
        .rom_idx(rom_idx), .src(src_d)
    );

    io_ctrl_regs #(
        .DATA_W(DATA_W), .NUM_HOST(NUM_HOST), .NUM_SCR(NUM_SCR),
        .NUM_TMR(NUM_TMR), .DSP_AW(DSP_AW)
    ) u_regs (
        .clk(clk), .rst(rst), .wr_io(wr_io), .ofs(ofs), .wdata(cpu_wdata),
        .host_wr(host_wr), .host_idx(host_idx), .host_wdata(host_wdata),
        .latch_q(latch_q), .rom_en(rom_en), .tmr_en(tmr_en),
        .tmr_target(tmr_target), .host_in(host_in), .host_out(host_out),
        .scratch(scratch_out), .dsp_we(dsp_we), .dsp_addr(dsp_addr),
        .dsp_wdata(dsp_wdata)
    );

    io_read_path #(
        .DATA_W(DATA_W), .NUM_HOST(NUM_HOST), .NUM_SCR(NUM_SCR),
        .NUM_TMR(NUM_TMR), .TCNT_W(TCNT_W), .ROM_BYTES(ROM_BYTES),
        .BOOT_IMAGE(BOOT_IMAGE)
    ) u_rd (
        .clk(clk), .rst(rst), .rd_req(rd_req), .in_io(in_io), .ofs(ofs),
        .src_d(src_d), .rom_idx(rom_idx), .latch_q(latch_q),
        .dsp_rdata(dsp_rdata), .host_in(host_in), .scratch(scratch_out),
        .tmr_count(tmr_count), .ram_rdata(ram_rdata), .cpu_rdata(cpu_rdata),
        .tmr_clr(tmr_clr)
    );

    // R10
    ram_fallthrough_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && cpu_we) |-> ram_we && (ram_addr == cpu_addr) && (ram_wdata == cpu_wdata));

    // R4
    dsp_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        dsp_we |-> cpu_req && cpu_we);

endmodule

// File: tb/tb_spc_io_decoder.sv
module tb_spc_io_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic [15:0] ram_addr;
    logic        ram_re, ram_we;
    logic [7:0]  ram_wdata;
    logic [7:0]  ram_rdata = '0;
    logic [6:0]  dsp_addr;
    logic        dsp_we;
    logic [7:0]  dsp_wdata, dsp_rdata;
    logic        host_wr = 1'b0;
    logic [1:0]  host_idx = '0;
    logic [7:0]  host_wdata = '0;
    logic [31:0] host_out;
    logic [15:0] scratch_out;
    logic [2:0]  tmr_en;
    logic [23:0] tmr_target;
    logic [11:0] tmr_count = 12'hF93;
    logic [2:0]  tmr_clr;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    spc_io_decoder dut (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .ram_addr(ram_addr), .ram_re(ram_re), .ram_we(ram_we),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .dsp_addr(dsp_addr),
        .dsp_we(dsp_we), .dsp_wdata(dsp_wdata), .dsp_rdata(dsp_rdata),
        .host_wr(host_wr), .host_idx(host_idx), .host_wdata(host_wdata),
        .host_out(host_out), .scratch_out(scratch_out), .tmr_en(tmr_en),
        .tmr_target(tmr_target), .tmr_count(tmr_count), .tmr_clr(tmr_clr)
    );

    // RAM model: unwritten bytes read as a hash of the address.
    logic [7:0] ram_m [logic [15:0]];
    function automatic logic [7:0] hash(input logic [15:0] a);
        return a[15:8] ^ a[7:0] ^ 8'h5A;
    endfunction
    always @(posedge clk) begin
        if (ram_re) ram_rdata <= ram_m.exists(ram_addr) ? ram_m[ram_addr] : hash(ram_addr);
        if (ram_we) ram_m[ram_addr] = ram_wdata;
    end

    // DSP register model.
    logic [7:0] dsp_m [128];
    initial for (int i = 0; i < 128; i++) dsp_m[i] = '0;
    assign dsp_rdata = dsp_m[dsp_addr];
    always @(posedge clk) if (dsp_we) dsp_m[dsp_addr] <= dsp_wdata;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cpu_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic cpu_rd(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a;
        @(negedge clk);
        cpu_req = 1'b0;
        #1 d = cpu_rdata;
    endtask

    task automatic host_put(input logic [1:0] i, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_idx = i; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    typedef struct packed {
        logic        we;
        logic [15:0] a;
        logic [7:0]  d;
        logic [7:0]  e;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 16'h00F2, 8'h05, 8'h00, 8'd3},   // R3 latch
        '{1'b0, 16'h00F2, 8'h00, 8'h05, 8'd3},
        '{1'b1, 16'h00F3, 8'h77, 8'h00, 8'd3},
        '{1'b0, 16'h00F3, 8'h00, 8'h77, 8'd3},
        '{1'b1, 16'h00F2, 8'h85, 8'h00, 8'd4},   // R4 latch >= 0x80
        '{1'b0, 16'h00F2, 8'h00, 8'h85, 8'd3},
        '{1'b0, 16'h00F3, 8'h00, 8'h77, 8'd3},   // masked to 7 bits
        '{1'b1, 16'h00F3, 8'h11, 8'h00, 8'd4},   // discarded
        '{1'b1, 16'h00F2, 8'h05, 8'h00, 8'd4},
        '{1'b0, 16'h00F3, 8'h00, 8'h77, 8'd4},
        '{1'b1, 16'h00F8, 8'h3C, 8'h00, 8'd6},   // R6 scratch
        '{1'b1, 16'h00F9, 8'hC3, 8'h00, 8'd6},
        '{1'b0, 16'h00F8, 8'h00, 8'h3C, 8'd6},
        '{1'b0, 16'h00F9, 8'h00, 8'hC3, 8'd6},
        '{1'b0, 16'h00F0, 8'h00, 8'h00, 8'd2},   // R2 zero reads
        '{1'b1, 16'h00FA, 8'h10, 8'h00, 8'd7},
        '{1'b0, 16'h00FA, 8'h00, 8'h00, 8'd2},
        '{1'b0, 16'h00FB, 8'h00, 8'h00, 8'd2},
        '{1'b0, 16'h00FC, 8'h00, 8'h00, 8'd2},
        '{1'b0, 16'h00F1, 8'h00, 8'h00, 8'd2},
        '{1'b0, 16'h1234, 8'h00, 8'h7C, 8'd12},  // R12 RAM read
        '{1'b1, 16'h1234, 8'hAB, 8'h00, 8'd10},  // R10
        '{1'b0, 16'h1234, 8'h00, 8'hAB, 8'd10},
        '{1'b0, 16'hFFC0, 8'h00, 8'hA5, 8'd9},   // R9 overlay
        '{1'b0, 16'hFFFF, 8'h00, 8'h9A, 8'd9},
        '{1'b0, 16'hFFBF, 8'h00, 8'h1A, 8'd9},
        '{1'b0, 16'h0000, 8'h00, 8'h5A, 8'd12}
    };

    initial begin
        #(8 * 100000);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1 tmr_en",     32'(tmr_en), 32'h0);
        chk("R1 tmr_target", 32'(tmr_target), 32'h0);
        chk("R1 host_out",   host_out, 32'h0);
        chk("R1 scratch",    32'(scratch_out), 32'h0);
        chk("R1 tmr_clr",    32'(tmr_clr), 32'h0);
        cpu_rd(16'h00F2, rd); chk("R1 latch", 32'(rd), 32'h00);
        cpu_rd(16'h00F4, rd); chk("R1 host_in", 32'(rd), 32'h00);
        cpu_rd(16'hFFC0, rd); chk("R1 overlay on", 32'(rd), 32'hA5);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            if (VEC[i].we) cpu_wr(VEC[i].a, VEC[i].d);
            else begin
                cpu_rd(VEC[i].a, rd);
                chk($sformatf("R%0d vec%0d @%h", VEC[i].rq, i, VEC[i].a), 32'(rd), 32'(VEC[i].e));
            end
        end

        // R7 targets and enables
        chk("R7 target0", 32'(tmr_target[7:0]), 32'h10);
        cpu_wr(16'h00FB, 8'h40); chk("R7 target1", 32'(tmr_target[15:8]), 32'h40);
        cpu_wr(16'h00FC, 8'h7F); chk("R7 target2", 32'(tmr_target[23:16]), 32'h7F);
        cpu_wr(16'h00F1, 8'h85); chk("R7 tmr_en", 32'(tmr_en), 32'h5);

        // R10 I/O writes reached RAM
        chk("R10 ram F2", 32'(ram_m[16'h00F2]), 32'h05);
        chk("R10 ram F3", 32'(ram_m[16'h00F3]), 32'h11);
        chk("R10 ram F1", 32'(ram_m[16'h00F1]), 32'h85);
        chk("R4 dsp reg kept", 32'(dsp_m[5]), 32'h77);

        // R9 overlay switching, R10 write under overlay
        cpu_wr(16'hFFC1, 8'hEE);
        cpu_rd(16'hFFC1, rd); chk("R9 overlay hides ram", 32'(rd), 32'hA4);
        cpu_wr(16'h00F1, 8'h05);
        cpu_rd(16'hFFC0, rd); chk("R9 overlay off", 32'(rd), 32'h65);
        cpu_rd(16'hFFC1, rd); chk("R10 write under overlay", 32'(rd), 32'hEE);
        cpu_wr(16'h00F1, 8'h80);
        cpu_rd(16'hFFC0, rd); chk("R9 overlay back", 32'(rd), 32'hA5);

        // R5 host mailboxes
        host_put(2'd0, 8'h11); host_put(2'd1, 8'h22);
        host_put(2'd2, 8'h33); host_put(2'd3, 8'h44);
        cpu_rd(16'h00F4, rd); chk("R5 in0", 32'(rd), 32'h11);
        cpu_rd(16'h00F7, rd); chk("R5 in3", 32'(rd), 32'h44);
        cpu_wr(16'h00F5, 8'h99);
        chk("R5 out1", 32'(host_out[15:8]), 32'h99);
        cpu_rd(16'h00F5, rd); chk("R5 read is input", 32'(rd), 32'h22);

        // R8 paired clears
        cpu_wr(16'h00F1, 8'h90);
        cpu_rd(16'h00F4, rd); chk("R8 lo clr in0", 32'(rd), 32'h00);
        cpu_rd(16'h00F5, rd); chk("R8 lo clr in1", 32'(rd), 32'h00);
        cpu_rd(16'h00F6, rd); chk("R8 hi kept", 32'(rd), 32'h33);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 16'h00F1; cpu_wdata = 8'hA0;
        host_wr = 1'b1; host_idx = 2'd2; host_wdata = 8'h55;
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0; host_wr = 1'b0;
        cpu_rd(16'h00F6, rd); chk("R8 clear wins", 32'(rd), 32'h00);
        cpu_rd(16'h00F7, rd); chk("R8 hi clr in3", 32'(rd), 32'h00);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 16'h00F1; cpu_wdata = 8'hA0;
        host_wr = 1'b1; host_idx = 2'd0; host_wdata = 8'h66;
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0; host_wr = 1'b0;
        cpu_rd(16'h00F4, rd); chk("R8 other pair write", 32'(rd), 32'h66);

        // R11 counters with clear pulses
        for (int t = 0; t < 3; t++) begin
            @(negedge clk);
            cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 16'(16'h00FD + t);
            #1 chk($sformatf("R11 clr pulse t%0d", t), 32'(tmr_clr), 32'(3'b001 << t));
            @(negedge clk);
            cpu_req = 1'b0;
            #1;
            chk($sformatf("R11 count t%0d", t), 32'(cpu_rdata), 32'(tmr_count[t*4 +: 4]));
            chk("R11 clr gone", 32'(tmr_clr), 32'h0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule